// File: doc/BRIEF.md
# Partial-Address Load Disambiguation Unit

This block sits beside a store queue and lets a load begin its cache access before its full effective address is known. A small group of low-order address bits reaches the block early. They are compared against every older store still held in the queue. The comparison produces a conservative first verdict: proceed, wait because a store may overlap, or wait because an older store has no address yet. The low bits are also passed on at once, so the data and tag arrays can begin indexing.

Some cycles later the full load address arrives. The block repeats the check on every address bit, against the same set of older stores that are still in the queue. It issues a final verdict. That final verdict clears a false dependence raised by the partial compare and confirms a true one. Stores are allocated in program order, receive their addresses out of order by queue index, and leave the queue from the oldest end when they commit.

Top module: `lsd_partial_disambig`

## Requirements
- R1: After reset, no verdict or index pulse is produced, the queue is empty (`sq_full_o`=0), and the next allocation index is 0.
- R2: Stores are allocated in order. `st_alloc_idx_o` shows the slot the next allocation takes; it increments and wraps from SQ_DEPTH-1 to 0. `sq_full_o` is 1 exactly when SQ_DEPTH stores are held.
- R3: An early verdict pulses on `early_vld_o` PART_LAT (3) clock edges after the cycle in which `ld_part_vld_i` is sampled. It carries that load's tag on `early_tag_o`. Verdict codes: 0 = proceed, 1 = wait-dependent, 2 = wait-unknown.
- R4: If any older store has no address yet, the early verdict is 2, whatever the bit compare shows.
- R5: If all older stores have addresses and any of them equals the load on the low LO_W (8) bits, the early verdict is 1, even when the upper bits differ.
- R6: If all older stores have addresses and none matches on the low bits, the early verdict is 0.
- R7: Only stores held in the queue when the partial address is sampled count as older. A store allocated in that same cycle or later is ignored by both the early and the final check.
- R8: One edge after `ld_part_vld_i` is sampled, `ix_vld_o` pulses and `ix_lo_o` carries the partial bits, for every verdict.
- R9: A final verdict pulses on `final_vld_o` FULL_LAT (5) edges after `ld_full_vld_i` is sampled, with the load's tag and the same codes. It is decided by an exact all-bit compare over that load's older stores still in the queue: 2 if any of them still lacks an address, else 1 on an exact match, else 0.
- R10: A load whose early verdict was 1 only because of a low-bit match gets a final verdict of 0.
- R11: `st_commit_i` removes the oldest store. A committed store no longer takes part in any later final check, even if its slot is reallocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_alloc_i | input | 1 | Allocate a store at the queue tail |
| st_alloc_idx_o | output | IDX_W | Slot the next allocation takes |
| sq_full_o | output | 1 | Queue holds SQ_DEPTH stores |
| st_addr_vld_i | input | 1 | Store address write strobe |
| st_addr_idx_i | input | IDX_W | Queue slot that receives the address |
| st_addr_i | input | AW | Store full address |
| st_commit_i | input | 1 | Retire the oldest store |
| ld_part_vld_i | input | 1 | Early partial load address valid |
| ld_part_tag_i | input | TAG_W | Load tag for the partial address |
| ld_part_lo_i | input | LO_W | Low bits of the load address |
| ld_full_vld_i | input | 1 | Full load address valid |
| ld_full_tag_i | input | TAG_W | Load tag for the full address |
| ld_full_addr_i | input | AW | Full load address |
| ix_vld_o | output | 1 | Early cache index valid |
| ix_lo_o | output | LO_W | Early cache index bits |
| early_vld_o | output | 1 | Partial-check verdict valid |
| early_tag_o | output | TAG_W | Tag of the partial verdict |
| early_kind_o | output | 2 | Partial verdict code |
| final_vld_o | output | 1 | Exact-check verdict valid |
| final_tag_o | output | TAG_W | Tag of the final verdict |
| final_kind_o | output | 2 | Final verdict code |

## Verification
A wrong per-load snapshot of older stores shows up as a wrong final verdict. If a committed store is not removed from the snapshot, the final code is 1 where 0 is due. If a store allocated in the same cycle is included, the code is 2 where 0 is due. Either error appears FULL_LAT edges after the full address. A stale known flag or a stale address in a queue slot corrupts the next early verdict after PART_LAT edges. Pointer errors show up right away on `st_alloc_idx_o` and `sq_full_o`, and are exercised through a full wrap of the queue.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    VD_GO  = 2'd0,
    VD_DEP = 2'd1,
    VD_UNK = 2'd2
  } verdict_e;
endpackage

// File: rtl/lsd_delay.sv
module lsd_delay #(
  parameter int LAT = 3,
  parameter int W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic [LAT-1:0]        v_q;
  logic [LAT-1:0][W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q[0] <= vld_i;
      d_q[0] <= dat_i;
      for (int s = 1; s < LAT; s++) begin
        v_q[s] <= v_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign vld_o = v_q[LAT-1];
  assign dat_o = d_q[LAT-1];
endmodule

// File: rtl/lsd_store_queue.sv
module lsd_store_queue #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  output logic [IDX_W-1:0]          alloc_idx_o,
  output logic                      full_o,
  input  logic                      addr_vld_i,
  input  logic [IDX_W-1:0]          addr_idx_i,
  input  logic [AW-1:0]             addr_i,
  input  logic                      commit_i,
  output logic [DEPTH-1:0]          commit_oh_o,
  output logic [DEPTH-1:0]          valid_o,
  output logic [DEPTH-1:0]          known_o,
  output logic [DEPTH-1:0][AW-1:0]  addr_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] valid_q, known_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic do_alloc, do_commit;

  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign do_alloc  = alloc_i && !full_o;
  assign do_commit = commit_i && (cnt_q != '0);

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_alloc)  tail_q <= nxt(tail_q);
      if (do_commit) head_q <= nxt(head_q);
      if (do_alloc && !do_commit)      cnt_q <= cnt_q + 1'b1;
      else if (do_commit && !do_alloc) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        known_q[i] <= 1'b0;
        addr_q[i]  <= '0;
      end else begin
        if (do_alloc && tail_q == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          known_q[i] <= 1'b0;
        end else if (do_commit && head_q == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
          known_q[i] <= 1'b0;
        end else if (addr_vld_i && addr_idx_i == IDX_W'(i) && valid_q[i]) begin
          known_q[i] <= 1'b1;
          addr_q[i]  <= addr_i;
        end
      end
    end
    assign commit_oh_o[i] = do_commit && (head_q == IDX_W'(i));
  end

  assign alloc_idx_o = tail_q;
  assign valid_o     = valid_q;
  assign known_o     = known_q;
  assign addr_o      = addr_q;

  // R2
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_q) == int'(cnt_q));
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && full_o));
  // R11
  head_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> valid_q[head_q]);
endmodule

// File: rtl/lsd_match.sv
module lsd_match #(
  parameter int DEPTH = 16,
  parameter int CW    = 8
) (
  input  logic [DEPTH-1:0]          mask_i,
  input  logic [DEPTH-1:0]          known_i,
  input  logic [DEPTH-1:0][CW-1:0]  addr_i,
  input  logic [CW-1:0]             probe_i,
  output logic [1:0]                kind_o
);
  import lsd_pkg::*;
  logic [DEPTH-1:0] hit, unk;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign unk[i] = mask_i[i] && !known_i[i];
    assign hit[i] = mask_i[i] && known_i[i] && (addr_i[i] == probe_i);
  end

  always_comb begin
    if (|unk)      kind_o = VD_UNK;
    else if (|hit) kind_o = VD_DEP;
    else           kind_o = VD_GO;
  end
endmodule

// File: rtl/lsd_partial_disambig.sv
module lsd_partial_disambig #(
  parameter int AW       = 32,
  parameter int LO_W     = 8,
  parameter int SQ_DEPTH = 16,
  parameter int TAG_W    = 3,
  parameter int PART_LAT = 3,
  parameter int FULL_LAT = 5,
  localparam int IDX_W = $clog2(SQ_DEPTH),
  localparam int NTAG  = 1 << TAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_alloc_i,
  output logic [IDX_W-1:0] st_alloc_idx_o,
  output logic             sq_full_o,
  input  logic             st_addr_vld_i,
  input  logic [IDX_W-1:0] st_addr_idx_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic             st_commit_i,
  input  logic             ld_part_vld_i,
  input  logic [TAG_W-1:0] ld_part_tag_i,
  input  logic [LO_W-1:0]  ld_part_lo_i,
  input  logic             ld_full_vld_i,
  input  logic [TAG_W-1:0] ld_full_tag_i,
  input  logic [AW-1:0]    ld_full_addr_i,
  output logic             ix_vld_o,
  output logic [LO_W-1:0]  ix_lo_o,
  output logic             early_vld_o,
  output logic [TAG_W-1:0] early_tag_o,
  output logic [1:0]       early_kind_o,
  output logic             final_vld_o,
  output logic [TAG_W-1:0] final_tag_o,
  output logic [1:0]       final_kind_o
);
  logic [SQ_DEPTH-1:0]           sq_valid, sq_known, commit_oh;
  logic [SQ_DEPTH-1:0][AW-1:0]   sq_addr;
  logic [SQ_DEPTH-1:0][LO_W-1:0] sq_lo;
  logic [NTAG-1:0][SQ_DEPTH-1:0] snap_q;
  logic [NTAG-1:0]               pend_q;
  logic [SQ_DEPTH-1:0]           snap_any;
  logic [1:0]                    part_kind, full_kind;

  lsd_store_queue #(.DEPTH(SQ_DEPTH), .AW(AW)) u_sq (
    .clk_i, .rst_ni,
    .alloc_i(st_alloc_i), .alloc_idx_o(st_alloc_idx_o), .full_o(sq_full_o),
    .addr_vld_i(st_addr_vld_i), .addr_idx_i(st_addr_idx_i), .addr_i(st_addr_i),
    .commit_i(st_commit_i), .commit_oh_o(commit_oh),
    .valid_o(sq_valid), .known_o(sq_known), .addr_o(sq_addr)
  );

  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_lo
    assign sq_lo[i] = sq_addr[i][LO_W-1:0];
  end

  // lossy phase: every store present now is older than this load
  lsd_match #(.DEPTH(SQ_DEPTH), .CW(LO_W)) u_part (
    .mask_i(sq_valid), .known_i(sq_known), .addr_i(sq_lo),
    .probe_i(ld_part_lo_i), .kind_o(part_kind)
  );

  // exact phase against the load's surviving older stores
  lsd_match #(.DEPTH(SQ_DEPTH), .CW(AW)) u_full (
    .mask_i(snap_q[ld_full_tag_i]), .known_i(sq_known), .addr_i(sq_addr),
    .probe_i(ld_full_addr_i), .kind_o(full_kind)
  );

  for (genvar t = 0; t < NTAG; t++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        snap_q[t] <= '0;
        pend_q[t] <= 1'b0;
      end else if (ld_part_vld_i && ld_part_tag_i == TAG_W'(t)) begin
        snap_q[t] <= sq_valid & ~commit_oh;
        pend_q[t] <= 1'b1;
      end else begin
        snap_q[t] <= snap_q[t] & ~commit_oh;
        if (ld_full_vld_i && ld_full_tag_i == TAG_W'(t)) pend_q[t] <= 1'b0;
      end
    end
  end

  always_comb begin
    snap_any = '0;
    for (int t = 0; t < NTAG; t++) snap_any |= snap_q[t];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ix_vld_o <= 1'b0;
      ix_lo_o  <= '0;
    end else begin
      ix_vld_o <= ld_part_vld_i;
      if (ld_part_vld_i) ix_lo_o <= ld_part_lo_i;
    end
  end

  lsd_delay #(.LAT(PART_LAT), .W(TAG_W + 2)) u_early_dly (
    .clk_i, .rst_ni, .vld_i(ld_part_vld_i), .dat_i({ld_part_tag_i, part_kind}),
    .vld_o(early_vld_o), .dat_o({early_tag_o, early_kind_o})
  );

  lsd_delay #(.LAT(FULL_LAT), .W(TAG_W + 2)) u_final_dly (
    .clk_i, .rst_ni, .vld_i(ld_full_vld_i), .dat_i({ld_full_tag_i, full_kind}),
    .vld_o(final_vld_o), .dat_o({final_tag_o, final_kind_o})
  );

  // R11
  snap_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_any & ~sq_valid) == '0);
  // R9
  full_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_full_vld_i |-> pend_q[ld_full_tag_i]);
  // R8
  ix_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_part_vld_i |=> (ix_vld_o && ix_lo_o == $past(ld_part_lo_i)));
  // R3
  early_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_vld_o |-> (early_kind_o != 2'd3));
  // R9
  final_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_vld_o |-> (final_kind_o != 2'd3));
endmodule

// File: tb/lsd_partial_disambig_tb.sv
module lsd_partial_disambig_tb;
  localparam int AW = 32, LO_W = 8, DEP = 16, TW = 3, PL = 3, FL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_alloc = 0, st_addr_vld = 0, st_commit = 0;
  logic [3:0] st_addr_idx = '0, alloc_idx;
  logic [AW-1:0] st_addr = '0, full_addr = '0;
  logic sq_full, part_vld = 0, full_vld = 0;
  logic [TW-1:0] part_tag = '0, full_tag = '0, e_tag, f_tag;
  logic [LO_W-1:0] part_lo = '0, ix_lo;
  logic ix_vld, e_vld, f_vld;
  logic [1:0] e_kind, f_kind;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lsd_partial_disambig u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_alloc_i(st_alloc), .st_alloc_idx_o(alloc_idx), .sq_full_o(sq_full),
    .st_addr_vld_i(st_addr_vld), .st_addr_idx_i(st_addr_idx), .st_addr_i(st_addr),
    .st_commit_i(st_commit),
    .ld_part_vld_i(part_vld), .ld_part_tag_i(part_tag), .ld_part_lo_i(part_lo),
    .ld_full_vld_i(full_vld), .ld_full_tag_i(full_tag), .ld_full_addr_i(full_addr),
    .ix_vld_o(ix_vld), .ix_lo_o(ix_lo),
    .early_vld_o(e_vld), .early_tag_o(e_tag), .early_kind_o(e_kind),
    .final_vld_o(f_vld), .final_tag_o(f_tag), .final_kind_o(f_kind)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic alloc(int exp_idx);
    @(negedge clk);
    chk("R2 alloc idx", alloc_idx, exp_idx);
    st_alloc = 1;
    @(posedge clk); @(negedge clk);
    st_alloc = 0;
  endtask

  task automatic set_addr(int idx, logic [AW-1:0] a);
    @(negedge clk);
    st_addr_vld = 1; st_addr_idx = idx[3:0]; st_addr = a;
    @(posedge clk); @(negedge clk);
    st_addr_vld = 0;
  endtask

  task automatic commit();
    @(negedge clk);
    st_commit = 1;
    @(posedge clk); @(negedge clk);
    st_commit = 0;
  endtask

  task automatic part(string req, int tag, int lo, int exp_kind, bit with_alloc);
    @(negedge clk);
    part_vld = 1; part_tag = tag[TW-1:0]; part_lo = lo[LO_W-1:0];
    st_alloc = with_alloc;
    @(posedge clk); @(negedge clk);
    part_vld = 0; st_alloc = 0;
    chk("R8 ix vld", ix_vld, 1);
    chk("R8 ix bits", ix_lo, lo);
    chk("R3 early too soon", e_vld, 0);
    repeat (PL - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 early vld", e_vld, 1);
    chk("R3 early tag", e_tag, tag);
    chk(req, e_kind, exp_kind);
    @(negedge clk);
    chk("R3 early one pulse", e_vld, 0);
  endtask

  task automatic full(string req, int tag, logic [AW-1:0] a, int exp_kind);
    @(negedge clk);
    full_vld = 1; full_tag = tag[TW-1:0]; full_addr = a;
    @(posedge clk); @(negedge clk);
    full_vld = 0;
    repeat (FL - 2) @(posedge clk);
    @(negedge clk);
    chk("R9 final too soon", f_vld, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 final vld", f_vld, 1);
    chk("R9 final tag", f_tag, tag);
    chk(req, f_kind, exp_kind);
  endtask

  task automatic t_reset();
    chk("R1 full", sq_full, 0);
    chk("R1 idx", alloc_idx, 0);
    chk("R1 early", e_vld, 0);
    chk("R1 final", f_vld, 0);
    chk("R1 ix", ix_vld, 0);
  endtask

  task automatic t_basic();
    alloc(0); alloc(1);
    set_addr(0, 32'h1000_0010);
    set_addr(1, 32'h2000_0020);
    part("R6 no low match", 1, 'h30, 0, 0);
    full("R9 exact miss", 1, 32'h3000_0030, 0);
    part("R5 low match differs high", 2, 'h10, 1, 0);
    full("R10 false dep cleared", 2, 32'h5555_0010, 0);
    part("R5 true low match", 3, 'h20, 1, 0);
    full("R9 exact hit", 3, 32'h2000_0020, 1);
  endtask

  task automatic t_unknown();
    alloc(2);
    part("R4 unknown older", 4, 'h99, 2, 0);
    full("R9 still unknown", 4, 32'h0000_0099, 2);
    set_addr(2, 32'h0000_0099);
    part("R5 known now", 4, 'h99, 1, 0);
    full("R9 exact after known", 4, 32'h0000_0099, 1);
  endtask

  task automatic t_younger();
    part("R7 same-cycle alloc ignored", 5, 'h77, 0, 1);
    full("R7 younger unknown ignored", 5, 32'h0000_0077, 0);
    set_addr(3, 32'hABCD_0044);
  endtask

  task automatic t_commit();
    part("R5 oldest matches", 6, 'h10, 1, 0);
    commit();
    full("R11 committed excluded", 6, 32'h1000_0010, 0);
  endtask

  task automatic t_wrap();
    commit(); commit(); commit();
    chk("R2 empty not full", sq_full, 0);
    for (int k = 0; k < DEP; k++) alloc((4 + k) % DEP);
    chk("R2 full flag", sq_full, 1);
    chk("R2 idx after wrap", alloc_idx, 4);
    part("R4 all unknown", 7, 'h01, 2, 0);
    for (int k = 0; k < DEP; k++) commit();
    chk("R2 drained", sq_full, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_unknown();
    t_younger();
    t_commit();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule